// File: doc/BRIEF.md
# Cell Transmit Master for a Multi-PHY Cell Bus

This block moves fixed-size 53-byte cells from an internal word stream out onto a shared cell bus that serves up to four physical-layer devices. It repeatedly places PHY addresses on a 5-bit address bus and listens to each device's room indication. It starts a cell to a device only after that device has answered a poll with "room for a whole cell", and then sends every word of the cell with a start marker on the first word and an odd parity bit on every word. The bus is 16 bits wide by default, which gives 27 words per cell with a pad half-word at the end. It can be built 8 bits wide, which gives 53 words per cell.

On the stream side, the user presents words with a valid/ready handshake. The first word of each cell carries a start flag and the index of the destination PHY. While the block is polling, a cell head is held until its PHY has room. Words that arrive without a start flag while no cell is open are taken and dropped, so the block finds the next cell boundary by itself. If a start flag arrives before the open cell is complete, the block raises a one-clock error pulse and cuts the open cell short. It then treats the flagged word as the head of a new cell.

The controller has three states. ST_POLL steps the poll address and waits for a cell head whose PHY has room. ST_SELECT shows the chosen PHY address for one clock with no data. ST_SEND streams the words with the address parked at the null value 0x1F. The transitions are:
- ST_POLL to ST_SELECT when a cell head is waiting and its PHY has room.
- ST_SELECT to ST_SEND always.
- ST_SEND to ST_POLL when the last word is accepted, or when an early start flag is seen.
- ST_POLL to ST_POLL in every other case.

Top module: `utopia_tx_master`

## Requirements
- R1: While reset is held, bus_valid, bus_first, cell_err and every bit of bus_data are 0, and bus_parity is 1.
- R2: While no cell is being selected or sent, bus_addr steps through 0, 1, …, NUM_PHY-1 and wraps back to 0, advancing by one on every clock.
- R3: A cell for PHY p does not start until bus_room[p] has been seen high one clock after p appeared on bus_addr. While p shows no room, s_ready stays low for the cell head and bus_valid stays low.
- R4: The clock before the first word of a cell shows the destination PHY index on bus_addr with bus_valid low. bus_addr reads 0x1F (null) on every clock on which bus_valid is high.
- R5: A cell occupies exactly 27 bus words in 16-bit mode, or 53 words in 8-bit mode. bus_valid is high on each of those words, with no idle clock when the source keeps s_valid high. After the last word, bus_valid drops and polling addresses reappear.
- R6: bus_first is high on the first word of a cell and low on all other words.
- R7: On every word with bus_valid high, bus_data together with bus_parity holds an odd number of ones.
- R8: Each bus word equals the accepted stream word bit for bit. Bit DATA_W-1 is the most significant bit and bit 0 is the least significant.
- R9: A start flag that arrives at word index 1 or later of an open cell causes a one-clock cell_err pulse and ends the open cell at the words already sent. The flagged word then starts a new cell, which is sent in full.
- R10: Words presented without a start flag while no cell is open are accepted (s_ready high) and dropped without any bus_valid.
- R11: Sending a cell to PHY p uses up p's room indication. A following cell for p waits until p has been polled again and has answered with room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all signals are launched and sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted at the next rising edge |
| s_data | input | DATA_W | Stream word |
| s_first | input | 1 | Marks the first word of a cell |
| s_dest | input | PHY_W | Destination PHY index, read with the first word |
| bus_data | output | DATA_W | Cell data to the PHYs, MSB is bit DATA_W-1 |
| bus_first | output | 1 | High with the first word of a cell |
| bus_valid | output | 1 | High on each clock that carries cell data |
| bus_parity | output | 1 | Odd parity over bus_data |
| bus_addr | output | 5 | PHY address for polling and selection; 0x1F means none |
| bus_room | input | NUM_PHY | Per-PHY room answer, valid one clock after that PHY's poll |
| cell_err | output | 1 | One-clock pulse on an early start flag |

## Verification
Two functions can land on the same clock edge. One is the capture of a poll answer into a PHY's room flag. The other is the clearing of that same flag because the controller has just chosen that PHY. If the capture wins, a stale answer can launch a second cell into a device that has already filled up. The bench provokes this by queueing two cells for PHY 0 back to back and dropping PHY 0's room line as soon as the first word appears on the bus. It judges the result by requiring that exactly one cell emerges until room is raised again, after which the second cell arrives complete. A second overlap, an early start flag that both ends one cell and begins the next, is judged by the error pulse count, the truncated word count and the position of the new start marker.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [1:0] {
        ST_POLL,
        ST_SELECT,
        ST_SEND
    } utx_state_e;

    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] NULL_ADDR = 5'h1F;

    // words per cell: 16-bit bus pads the odd byte count up to a whole word
    function automatic int cell_words(input int data_w, input int cell_bytes);
        return (data_w == 16) ? (cell_bytes + 1) / 2 : cell_bytes;
    endfunction

endpackage

// File: rtl/utx_poll.sv
module utx_poll #(
    parameter int NUM_PHY = 4,
    parameter int PHY_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               poll_en,
    input  logic               seen_poll_i,
    input  logic [PHY_W-1:0]   seen_addr_i,
    input  logic [NUM_PHY-1:0] clav_i,
    input  logic               take_i,
    input  logic [PHY_W-1:0]   take_idx_i,
    output logic [PHY_W-1:0]   poll_idx_o,
    output logic [NUM_PHY-1:0] room_o
);

    localparam logic [PHY_W-1:0] LAST_IDX = PHY_W'(NUM_PHY - 1);

    logic             cap_v;
    logic [PHY_W-1:0] cap_idx;

    // round-robin poll pointer and answer-alignment pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_idx_o <= '0;
            cap_v      <= 1'b0;
            cap_idx    <= '0;
        end else begin
            cap_v   <= seen_poll_i;
            cap_idx <= seen_addr_i;
            if (poll_en) begin
                poll_idx_o <= (poll_idx_o == LAST_IDX) ? '0 : poll_idx_o + PHY_W'(1);
            end
        end
    end

    // room table: a selection clears the flag and beats a same-edge capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            room_o <= '0;
        end else begin
            for (int i = 0; i < NUM_PHY; i++) begin
                if (take_i && take_idx_i == PHY_W'(i)) begin
                    room_o[i] <= 1'b0;
                end else if (poll_en && cap_v && cap_idx == PHY_W'(i)) begin
                    room_o[i] <= clav_i[i];
                end
            end
        end
    end

    AST_POLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(poll_en)) |->
            (poll_idx_o == (($past(poll_idx_o) == LAST_IDX) ? '0 : $past(poll_idx_o) + PHY_W'(1)))); // R2

endmodule

// File: rtl/utx_out.sv
module utx_out
    import utx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              poll_d,
    input  logic              valid_d,
    input  logic              first_d,
    input  logic [DATA_W-1:0] data_d,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_poll,
    output logic              bus_valid,
    output logic              bus_first,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_parity
);

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_par;
    logic             par_d;

    // per-byte parity lanes, folded into one odd-parity bit
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_par[l] = ^data_d[l*8 +: 8];
    end
    assign par_d = ~(^lane_par);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr   <= NULL_ADDR;
            bus_poll   <= 1'b0;
            bus_valid  <= 1'b0;
            bus_first  <= 1'b0;
            bus_data   <= '0;
            bus_parity <= 1'b1;
        end else begin
            bus_addr  <= addr_d;
            bus_poll  <= poll_d;
            bus_valid <= valid_d;
            bus_first <= first_d;
            if (valid_d) begin
                bus_data   <= data_d;
                bus_parity <= par_d;
            end
        end
    end

    AST_FIRST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_first |-> bus_valid); // R6

    AST_NULL_DURING_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr == NULL_ADDR)); // R4

endmodule

// File: rtl/utopia_tx_master.sv
module utopia_tx_master
    import utx_pkg::*;
#(
    parameter  int DATA_W     = 16,
    parameter  int NUM_PHY    = 4,
    parameter  int CELL_BYTES = 53,
    localparam int PHY_W      = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [DATA_W-1:0]  s_data,
    input  logic               s_first,
    input  logic [PHY_W-1:0]   s_dest,
    output logic [DATA_W-1:0]  bus_data,
    output logic               bus_first,
    output logic               bus_valid,
    output logic               bus_parity,
    output logic [4:0]         bus_addr,
    input  logic [NUM_PHY-1:0] bus_room,
    output logic               cell_err
);

    localparam int WORDS = cell_words(DATA_W, CELL_BYTES);
    localparam int CNT_W = $clog2(WORDS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

    utx_state_e        state, state_nx;
    logic [PHY_W-1:0]  target;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              take, err_d, dest_ok;
    logic [ADDR_W-1:0] addr_d;
    logic              poll_d, valid_d, first_d;
    logic [PHY_W-1:0]  poll_idx;
    logic [NUM_PHY-1:0] room;
    logic              bus_poll;

    assign dest_ok = int'(s_dest) < NUM_PHY;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_POLL;
            target   <= '0;
            cnt      <= '0;
            cell_err <= 1'b0;
        end else begin
            state    <= state_nx;
            cnt      <= cnt_nx;
            cell_err <= err_d;
            if (take) begin
                target <= s_dest;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        take     = 1'b0;
        err_d    = 1'b0;
        s_ready  = 1'b0;
        addr_d   = NULL_ADDR;
        poll_d   = 1'b0;
        valid_d  = 1'b0;
        first_d  = 1'b0;
        unique case (state)
            ST_POLL: begin
                addr_d  = ADDR_W'(poll_idx);
                poll_d  = 1'b1;
                s_ready = s_valid && !s_first;
                if (s_valid && s_first && dest_ok && room[s_dest]) begin
                    take     = 1'b1;
                    state_nx = ST_SELECT;
                end
            end
            ST_SELECT: begin
                addr_d   = ADDR_W'(target);
                state_nx = ST_SEND;
            end
            ST_SEND: begin
                if (s_valid) begin
                    if (s_first && cnt != '0) begin
                        err_d    = 1'b1;
                        cnt_nx   = '0;
                        state_nx = ST_POLL;
                    end else begin
                        s_ready = 1'b1;
                        valid_d = 1'b1;
                        first_d = (cnt == '0);
                        if (cnt == LAST) begin
                            cnt_nx   = '0;
                            state_nx = ST_POLL;
                        end else begin
                            cnt_nx = cnt + CNT_W'(1);
                        end
                    end
                end
            end
            default: state_nx = ST_POLL;
        endcase
    end

    utx_poll #(
        .NUM_PHY (NUM_PHY),
        .PHY_W   (PHY_W)
    ) u_poll (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_en     (state == ST_POLL),
        .seen_poll_i (bus_poll),
        .seen_addr_i (bus_addr[PHY_W-1:0]),
        .clav_i      (bus_room),
        .take_i      (take),
        .take_idx_i  (s_dest),
        .poll_idx_o  (poll_idx),
        .room_o      (room)
    );

    utx_out #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_d     (addr_d),
        .poll_d     (poll_d),
        .valid_d    (valid_d),
        .first_d    (first_d),
        .data_d     (s_data),
        .bus_addr   (bus_addr),
        .bus_poll   (bus_poll),
        .bus_valid  (bus_valid),
        .bus_first  (bus_first),
        .bus_data   (bus_data),
        .bus_parity (bus_parity)
    );

    AST_ROOM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELECT) |-> !room[target]); // R11

    AST_ERR_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        cell_err |-> ($past(state) == ST_SEND && state == ST_POLL)); // R9

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R5

    AST_SELECT_SHOWS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_first |-> ($past(bus_addr) == ADDR_W'(target))); // R4

endmodule

// File: tb/tb_utopia_tx_master.sv
module tb_utopia_tx_master;

    localparam int DW = 16;
    localparam int NP = 4;
    localparam int NW = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid, s_ready, s_first;
    logic [DW-1:0] s_data;
    logic [1:0]    s_dest;
    logic [DW-1:0] bus_data;
    logic          bus_first, bus_valid, bus_parity, cell_err;
    logic [4:0]    bus_addr;
    logic [NP-1:0] bus_room;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    utopia_tx_master #(.DATA_W(DW), .NUM_PHY(NP), .CELL_BYTES(53)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_first(s_first), .s_dest(s_dest),
        .bus_data(bus_data), .bus_first(bus_first), .bus_valid(bus_valid),
        .bus_parity(bus_parity), .bus_addr(bus_addr), .bus_room(bus_room),
        .cell_err(cell_err)
    );

    // bus monitor: append-only capture
    logic [DW-1:0] cap_data  [0:1023];
    logic          cap_first [0:1023];
    int            cap_n = 0;
    int            par_bad = 0;
    int            gap_n = 0;
    int            err_n = 0;
    logic [4:0]    last_nonnull = 5'h1F;
    logic [4:0]    sel_addr = 5'h1F;
    logic          prev_valid = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid) begin
                cap_data[cap_n % 1024]  <= bus_data;
                cap_first[cap_n % 1024] <= bus_first;
                cap_n <= cap_n + 1;
                if ((^{bus_data, bus_parity}) !== 1'b1) par_bad <= par_bad + 1;
                if (bus_first) sel_addr <= last_nonnull;
                if (!prev_valid && !bus_first) gap_n <= gap_n + 1;
            end else if (bus_addr != 5'h1F) begin
                last_nonnull <= bus_addr;
            end
            prev_valid <= bus_valid;
            if (cell_err) err_n <= err_n + 1;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic sync();
        @(posedge clk);
        #1;
    endtask

    // present one word; returns one time unit after the accepting edge
    task automatic put_word(input logic [DW-1:0] d, input logic first, input logic [1:0] dest);
        bit acc;
        s_valid = 1'b1;
        s_data  = d;
        s_first = first;
        s_dest  = dest;
        do begin
            @(negedge clk);
            acc = s_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        s_valid = 1'b0;
        s_first = 1'b0;
    endtask

    task automatic send_cell(input logic [1:0] dest, input logic [7:0] seed, input int n);
        for (int k = 0; k < n; k++) begin
            put_word({seed, 8'(k)}, (k == 0), dest);
        end
    endtask

    task automatic wait_words(input int target, input int maxc);
        for (int c = 0; c < maxc && cap_n < target; c++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cell_cmp(input int base, input int n, input logic [7:0] seed,
                            output int dbad, output int fbad);
        dbad = 0;
        fbad = 0;
        for (int k = 0; k < n; k++) begin
            if (cap_data[(base + k) % 1024] !== {seed, 8'(k)}) dbad++;
            if (cap_first[(base + k) % 1024] !== (k == 0)) fbad++;
        end
    endtask

    // {room[3:0], dest[1:0], seed[7:0]}
    localparam logic [13:0] VEC [0:5] = '{
        {4'hF, 2'd0, 8'h11},
        {4'hF, 2'd3, 8'h5A},
        {4'h2, 2'd1, 8'hA5},
        {4'h8, 2'd3, 8'h00},
        {4'hF, 2'd2, 8'hFF},
        {4'h1, 2'd0, 8'h3C}
    };

    initial begin : main
        int base, e0, pb0, g0, dbad, fbad, prev, bad;
        s_valid = 1'b0; s_first = 1'b0; s_data = '0; s_dest = '0; bus_room = '0;

        // R1 reset values
        repeat (3) @(negedge clk);
        check(bus_valid == 1'b0, "R1 bus_valid in reset", bus_valid, 0);
        check(bus_first == 1'b0, "R1 bus_first in reset", bus_first, 0);
        check(cell_err == 1'b0, "R1 cell_err in reset", cell_err, 0);
        check(bus_data == '0, "R1 bus_data in reset", bus_data, 0);
        check(bus_parity == 1'b1, "R1 bus_parity in reset", bus_parity, 1);
        sync();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 round-robin poll addresses while idle
        prev = int'(bus_addr);
        bad = 0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (int'(bus_addr) != (prev + 1) % NP) bad++;
            prev = int'(bus_addr);
        end
        check(bad == 0, "R2 poll address steps", bad, 0);

        // table of full cells
        for (int v = 0; v < 6; v++) begin
            sync();
            bus_room = VEC[v][13:10];
            base = cap_n; pb0 = par_bad; g0 = gap_n;
            send_cell(VEC[v][9:8], VEC[v][7:0], NW);
            wait_words(base + NW, 50);
            cell_cmp(base, NW, VEC[v][7:0], dbad, fbad);
            check(cap_n - base == NW, "R5 cell word count", cap_n - base, NW);
            check(dbad == 0, "R8 data words match stream", dbad, 0);
            check(fbad == 0, "R6 start marker only on first word", fbad, 0);
            check(sel_addr == 5'(VEC[v][9:8]), "R4 select address", sel_addr, VEC[v][9:8]);
            check(par_bad == pb0, "R7 odd parity", par_bad - pb0, 0);
            check(gap_n == g0, "R5 no gap inside cell", gap_n - g0, 0);
            check(bus_valid == 1'b0 && bus_addr != 5'h1F, "R5 polling resumes after cell",
                  int'(bus_addr), 0);
        end

        // R3 cell held while its PHY has no room
        sync();
        bus_room = 4'b1011;
        base = cap_n;
        fork
            send_cell(2'd2, 8'h77, NW);
            begin
                repeat (40) @(negedge clk);
                check(cap_n == base, "R3 no words without room", cap_n - base, 0);
                bus_room = 4'b0100;
            end
        join
        wait_words(base + NW, 50);
        check(cap_n - base == NW, "R3 cell sent after room", cap_n - base, NW);
        check(sel_addr == 5'd2, "R3 selected PHY 2", sel_addr, 2);

        // R11 room consumed; same-edge capture must not relaunch
        sync();
        bus_room = 4'b0001;
        base = cap_n;
        fork
            begin
                send_cell(2'd0, 8'hC1, NW);
                send_cell(2'd0, 8'hC2, NW);
            end
            begin
                while (cap_n <= base) @(negedge clk);
                bus_room = 4'b0000;
                repeat (80) @(negedge clk);
                check(cap_n - base == NW, "R11 second cell waits for fresh room", cap_n - base, NW);
                bus_room = 4'b0001;
            end
        join
        wait_words(base + 2 * NW, 60);
        cell_cmp(base + NW, NW, 8'hC2, dbad, fbad);
        check(cap_n - base == 2 * NW, "R11 both cells delivered", cap_n - base, 2 * NW);
        check(dbad == 0 && fbad == 0, "R11 second cell intact", dbad + fbad, 0);

        // R9 early start flag
        sync();
        bus_room = 4'hF;
        base = cap_n; e0 = err_n;
        send_cell(2'd1, 8'h21, 10);
        send_cell(2'd1, 8'h42, NW);
        wait_words(base + 10 + NW, 200);
        check(err_n - e0 == 1, "R9 one error pulse", err_n - e0, 1);
        check(cap_n - base == 10 + NW, "R9 truncated plus full cell", cap_n - base, 10 + NW);
        cell_cmp(base, 10, 8'h21, dbad, fbad);
        check(dbad == 0 && fbad == 0, "R9 truncated words", dbad + fbad, 0);
        cell_cmp(base + 10, NW, 8'h42, dbad, fbad);
        check(dbad == 0 && fbad == 0, "R9 new cell after error", dbad + fbad, 0);

        // R10 stray words dropped, then resync
        sync();
        base = cap_n; e0 = err_n;
        for (int k = 0; k < 5; k++) put_word(16'hBEE0 + 16'(k), 1'b0, 2'd3);
        repeat (6) @(negedge clk);
        check(cap_n == base, "R10 stray words not sent", cap_n - base, 0);
        check(err_n == e0, "R10 no error on stray words", err_n - e0, 0);
        sync();
        send_cell(2'd3, 8'h9D, NW);
        wait_words(base + NW, 50);
        cell_cmp(base, NW, 8'h9D, dbad, fbad);
        check(cap_n - base == NW && dbad == 0 && fbad == 0, "R10 resync on next start",
              cap_n - base, NW);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule